// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that gives a host write and read access to a bank of clock-configuration registers. The system clock oversamples SCL and SDA through synchronizer chains. START and STOP conditions are recognised as SDA transitions while SCL is high. The slave pulls SDA low through an output enable and never drives it high.

A write transaction has a fixed layout. The address byte 0xD2 comes first. A command byte follows: it is acknowledged and its value is dropped. A byte-count byte comes next, and then the data bytes. The first data byte lands in register 0, the second in register 1 and the third in register 2. The host reads at address 0xD3, and the slave returns the registers in the same order, starting from register 0.

Some bit positions are not stored. They show the live levels of strap and stop pins. One bit shows a stored enable ANDed with an external stop pin. The stored register values go out on parallel ports to the clock control logic.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, cfg0_o is 0x08, cfg1_o is 0x07, cfg2_o is 0x00 and sda_oe is 0.
- R2: The slave acknowledges only address byte 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69. Any other address byte is not acknowledged, and the rest of that transaction is ignored until the next START.
- R3: On a write, the command byte and the byte-count byte are acknowledged and their values are dropped. Data bytes 1, 2 and 3 are written to registers 0, 1 and 2. All data bytes are acknowledged, and data bytes after the third are discarded.
- R4: A register changes only when a complete data byte is written to it, or on reset. Reads, foreign addresses and idle time leave every register unchanged.
- R5: Register 0 stores bits 7, 6, 5 and 3, and cfg0_o shows 0 in bits 4, 2, 1 and 0. On a read, bit 4 returns pin_cpu_stop_n, bits 2..0 return pin_fsel[2:0], and bit 3 returns the stored bit 3 ANDed with pin_pci_stop_n.
- R6: Register 1 stores bits 6..0 and cfg1_o bit 7 is 0. On a read, bit 7 returns pin_mult.
- R7: Register 2 stores all eight bits.
- R8: After address 0xD3, the slave sends register 0, then register 1, then register 2, each MSB first. Any further byte reads as 0x00. After the host's NACK, the slave releases SDA.
- R9: A STOP at any point returns the slave to idle. A START at any point restarts address reception. A data byte cut short by either condition writes nothing.
- R10: sda_oe = 1 pulls SDA low. sda_oe changes only while SCL is low, and an acknowledge stays asserted through the whole ninth SCL high phase.
- R11: pci_stop_eff_n equals stored register 0 bit 3 AND pin_pci_stop_n at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| pin_cpu_stop_n | input | 1 | CPU stop pin level, read back as register 0 bit 4 |
| pin_pci_stop_n | input | 1 | PCI stop pin level, ANDed into register 0 bit 3 |
| pin_fsel | input | 3 | Frequency select pins, read back as register 0 bits 2..0 |
| pin_mult | input | 1 | Multiplier pin level, read back as register 1 bit 7 |
| cfg0_o | output | 8 | Stored register 0 (unstored positions read 0) |
| cfg1_o | output | 8 | Stored register 1 (bit 7 reads 0) |
| cfg2_o | output | 8 | Stored register 2 |
| pci_stop_eff_n | output | 1 | Effective PCI stop: register 0 bit 3 AND pin |

## Verification
The bench builds the slave with SYNC_STAGES set to 3 and keeps the default address 0x69 and three registers. The deeper synchronizer delays every edge the slave sees by an extra cycle. That brings within reach the turnaround margins between a falling SCL, the slave moving or releasing SDA, and the host's next data change. The default address lets the near-miss addresses 0xD0, 0xA4 and the unshifted 0x69 be shown as not acknowledged.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int CFG_REGS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_t;

  // Bits a host write may change, per register
  function automatic logic [7:0] cfg_wmask(input int idx);
    case (idx)
      0:       return 8'hE8;
      1:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] cfg_rstval(input int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = CFG_REGS,
  localparam int        CW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_byte,
  output logic [CW-1:0] rd_idx,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  eng_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [6:0]    tx_sh;
  logic [1:0]    hdr_cnt;   // 0 address, 1 command, 2 count, 3 data
  logic [CW-1:0] data_cnt;
  logic          is_read;
  logic          m_ack;

  assign rd_idx = data_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      hdr_cnt  <= '0;
      data_cnt <= '0;
      is_read  <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        hdr_cnt  <= '0;
        data_cnt <= '0;
        is_read  <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (hdr_cnt == 2'd0 && shreg[7:1] != DEV_ADDR) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_RX_ACK;
                sda_oe <= 1'b1;
                if (hdr_cnt == 2'd0) is_read <= shreg[0];
                if (hdr_cnt != 2'd3) begin
                  hdr_cnt <= hdr_cnt + 2'd1;
                end else if (data_cnt != CW'(NREG)) begin
                  wr_en    <= 1'b1;
                  wr_idx   <= data_cnt;
                  wr_data  <= shreg;
                  data_cnt <= data_cnt + 1'b1;
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                state  <= ST_TX;
                tx_sh  <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
                if (data_cnt != CW'(NREG)) data_cnt <= data_cnt + 1'b1;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                state   <= ST_TX_ACK;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end else begin
                tx_sh   <= {tx_sh[5:0], 1'b0};
                sda_oe  <= ~tx_sh[6];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                state  <= ST_TX;
                tx_sh  <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
                if (data_cnt != CW'(NREG)) data_cnt <= data_cnt + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE); // R9
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX && bit_cnt == 4'd0 && hdr_cnt == 2'd0)); // R9
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10
  AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !is_read); // R3

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int  NREG = CFG_REGS,
  localparam int CW   = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [CW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  input  logic          pin_cpu_stop_n,
  input  logic          pin_pci_stop_n,
  input  logic [2:0]    pin_fsel,
  input  logic          pin_mult,
  output logic [7:0]    cfg_q [NREG],
  output logic          pci_stop_eff_n
);

  logic [7:0] q    [NREG];
  logic [7:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q[i] <= cfg_rstval(i);
      else if (wr_en && wr_idx == CW'(i))       q[i] <= wr_data & cfg_wmask(i);
    end
    assign cfg_q[i] = q[i];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == CW'(i)) |=> $stable(q[i])); // R4
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) view[k] = q[k];
    view[0] = {q[0][7:5], pin_cpu_stop_n, q[0][3] & pin_pci_stop_n, pin_fsel};
    view[1] = {pin_mult, q[1][6:0]};
  end

  assign rd_byte        = (rd_idx < CW'(NREG)) ? view[rd_idx] : 8'h00;
  assign pci_stop_eff_n = q[0][3] & pin_pci_stop_n;

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < CW'(NREG)); // R3

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       pin_cpu_stop_n,
  input  logic       pin_pci_stop_n,
  input  logic [2:0] pin_fsel,
  input  logic       pin_mult,
  output logic [7:0] cfg0_o,
  output logic [7:0] cfg1_o,
  output logic [7:0] cfg2_o,
  output logic       pci_stop_eff_n
);

  localparam int NREG = CFG_REGS;
  localparam int CW   = $clog2(NREG + 1);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rd_byte, wr_data;
  logic [CW-1:0] rd_idx, wr_idx;
  logic          wr_en;
  logic [7:0]    cfg_q [NREG];

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_byte_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smb_cfg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_byte(rd_byte),
    .pin_cpu_stop_n(pin_cpu_stop_n), .pin_pci_stop_n(pin_pci_stop_n),
    .pin_fsel(pin_fsel), .pin_mult(pin_mult),
    .cfg_q(cfg_q), .pci_stop_eff_n(pci_stop_eff_n)
  );

  assign cfg0_o = cfg_q[0];
  assign cfg1_o = cfg_q[1];
  assign cfg2_o = cfg_q[2];

  AST_PCI_EFFECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_pci_stop_n |-> !pci_stop_eff_n); // R11
  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && stop_det) |=> !sda_oe); // R10

endmodule

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_line;
  logic       sda_oe;
  logic       pin_cpu, pin_pci, pin_mult;
  logic [2:0] pin_fsel;
  logic [7:0] cfg0, cfg1, cfg2;
  logic       pci_eff;

  assign sda_line = sda_m & ~sda_oe;

  smb_cfg_slave #(.SYNC_STAGES(3)) u_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_cpu_stop_n(pin_cpu), .pin_pci_stop_n(pin_pci), .pin_fsel(pin_fsel),
    .pin_mult(pin_mult), .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2),
    .pci_stop_eff_n(pci_eff)
  );

  int         vecs = 0;
  int         errs = 0;
  logic       busy = 1'b1;
  logic       cmp_on = 1'b0;
  logic [7:0] exp_r [3];
  logic [7:0] wbuf [4];

  function automatic logic [7:0] keep_bits(input int k);
    if (k == 0) return 8'b1110_1000;
    if (k == 1) return 8'b0111_1111;
    return 8'b1111_1111;
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return {exp_r[0][7:5], pin_cpu, exp_r[0][3] & pin_pci, pin_fsel};
    if (k == 1) return {pin_mult, exp_r[1][6:0]};
    if (k == 2) return exp_r[2];
    return 8'h00;
  endfunction

  task automatic ck(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Idle-time model comparison every clock: R4 retention, R10 released bus, R11
  always @(negedge clk) begin
    if (cmp_on && !busy) begin
      vecs++;
      if ({cfg0, cfg1, cfg2, sda_oe, pci_eff} !==
          {exp_r[0], exp_r[1], exp_r[2], 1'b0, exp_r[0][3] & pin_pci}) begin
        errs++;
        $display("FAIL R4/R11 act=%h_%h_%h_%b_%b exp=%h_%h_%h_0_%b",
                 cfg0, cfg1, cfg2, sda_oe, pci_eff,
                 exp_r[0], exp_r[1], exp_r[2], exp_r[0][3] & pin_pci);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    scl_m = 1'b0; wt(4); sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8);
  endtask

  task automatic do_stop;
    scl_m = 1'b0; wt(4); sda_m = 1'b0; wt(4);
    scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl_m = 1'b0; wt(4); sda_m = b[i]; wt(4);
      scl_m = 1'b1; wt(8);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ackd);
    put_bits(b, 8);
    scl_m = 1'b0; wt(4); sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(1);
    ackd = ~sda_line; wt(6);
    ackd = ackd & ~sda_line; wt(1);   // R10: held across the ninth high phase
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wt(4); sda_m = 1'b1; wt(4);
      scl_m = 1'b1; wt(4); b[i] = sda_line; wt(4);
    end
    scl_m = 1'b0; wt(4); sda_m = ~mack; wt(4);
    scl_m = 1'b1; wt(8);
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input int n);
    logic a;
    busy = 1'b1;
    do_start;
    put_byte(8'hD2, a); ck("R2 write address ack", {7'd0, a}, 8'd1);
    put_byte(cmd, a);   ck("R3 command ack", {7'd0, a}, 8'd1);
    put_byte(n[7:0], a); ck("R3 count ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], a); ck("R3 data ack", {7'd0, a}, 8'd1);
      if (k < 3) exp_r[k] = wbuf[k] & keep_bits(k);
    end
    do_stop;
    busy = 1'b0;
    wt(4);
  endtask

  task automatic rd_txn(input int n);
    logic a;
    logic [7:0] b;
    busy = 1'b1;
    do_start;
    put_byte(8'hD3, a); ck("R2 read address ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, b);
      ck($sformatf("R8 read byte %0d (R5 R6 R7)", k), b, exp_rd(k));
    end
    ck("R8 released after NACK", {7'd0, sda_oe}, 8'd0);
    do_stop;
    busy = 1'b0;
    wt(4);
  endtask

  task automatic foreign(input logic [7:0] adr);
    logic a;
    busy = 1'b1;
    do_start;
    put_byte(adr, a);   ck("R2 foreign address NACK", {7'd0, a}, 8'd0);
    put_byte(8'h00, a); ck("R2 rest ignored", {7'd0, a}, 8'd0);
    put_byte(8'hFF, a); ck("R2 rest ignored", {7'd0, a}, 8'd0);
    do_stop;
    busy = 1'b0;
    wt(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    pin_cpu = 1'b1; pin_pci = 1'b1; pin_fsel = 3'b101; pin_mult = 1'b1;
    exp_r[0] = 8'h08; exp_r[1] = 8'h07; exp_r[2] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(2);
    ck("R1 cfg0 reset", cfg0, 8'h08);
    ck("R1 cfg1 reset", cfg1, 8'h07);
    ck("R1 cfg2 reset", cfg2, 8'h00);
    ck("R1 sda_oe reset", {7'd0, sda_oe}, 8'd0);
    busy = 1'b0; cmp_on = 1'b1;

    // R5 R6 R7: all ones, unstored positions stay 0
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    wr_txn(8'h00, 3);
    ck("R5 cfg0 after all-ones", cfg0, 8'hE8);
    ck("R6 cfg1 after all-ones", cfg1, 8'h7F);
    ck("R7 cfg2 after all-ones", cfg2, 8'hFF);
    rd_txn(3);

    // R3: command value ignored, fourth data byte discarded
    wbuf[0] = 8'h20; wbuf[1] = 8'h05; wbuf[2] = 8'h3C; wbuf[3] = 8'h99;
    wr_txn(8'hA5, 4);
    ck("R3 reg0 order", cfg0, 8'h20);
    ck("R3 reg1 order", cfg1, 8'h05);
    ck("R3 reg2 order, extra discarded", cfg2, 8'h3C);

    // R3: short write touches only the first register
    wbuf[0] = 8'hC8;
    wr_txn(8'h5A, 1);
    ck("R3 short write reg0", cfg0, 8'hC8);
    ck("R3 short write reg1 kept", cfg1, 8'h05);

    // R2 R4: foreign addresses
    foreign(8'hA4);
    foreign(8'hD0);
    foreign(8'h69);
    ck("R4 after foreign cfg0", cfg0, 8'hC8);

    // R8 R5 R6: read with varied pins, beyond-end byte is zero
    pin_cpu = 1'b0; pin_fsel = 3'b010; pin_mult = 1'b0;
    rd_txn(4);
    pin_pci = 1'b0; wt(2);
    ck("R11 pci effective with pin low", {7'd0, pci_eff}, 8'd0);
    rd_txn(1);
    pin_pci = 1'b1; pin_cpu = 1'b1; wt(2);
    ck("R11 pci effective with pin high", {7'd0, pci_eff}, 8'd1);

    // R9: data byte cut by STOP is not written
    busy = 1'b1;
    do_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h03, a);
    put_bits(8'h11, 4);
    do_stop;
    busy = 1'b0; wt(4);
    ck("R9 STOP aborts byte", cfg0, 8'hC8);

    // R9: repeated START mid-byte restarts with address reception
    busy = 1'b1;
    do_start;
    put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h03, a);
    put_bits(8'h00, 3);
    do_start;
    put_byte(8'hD3, a); ck("R9 address after repeated START", {7'd0, a}, 8'd1);
    get_byte(1'b0, b);  ck("R9 read restarts at reg0", b, exp_rd(0));
    do_stop;
    busy = 1'b0; wt(4);
    ck("R9 repeated START aborts byte", cfg0, 8'hC8);

    wt(20);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule